// File: doc/BRIEF.md
# Scoreboard Functional-Unit Dependency Matrix

This block is the hazard-tracking core of an out-of-order issue stage. It watches a small pool of functional units working over a small architectural register file. Every hazard is held as a single-bit cell in a per-unit matrix. A cell is set at issue from one-hot register tables and cleared by per-unit completion wires. No stored destination tag is compared on any cycle. An instruction is issued into a named unit with one destination and two source registers. From then on the unit gets two separate permissions: one to read its operands, and one to write its result. It reports back with a read-done pulse and a write-done pulse.

Speculation is handled by a set of shadow rows. Arming a row marks every unit issued from that cycle on as being under the row. Such a unit may read its operands and execute. Its result write is held until the row is resolved. A good resolution lifts the hold. A bad resolution cancels every unit under the row, and none of them writes. Shadow rows are interchangeable: one can stand for an unresolved branch and another for a possibly faulting operation.

Top module: `sb_dep_scoreboard`

## Requirements
- R1: After reset no unit is busy, `go_rd` and `go_wr` are all zero, no shadow row is live, and `iss_ready` is high for any request.
- R2: `go_rd[f]` is high exactly when unit f is busy, has not yet pulsed read-done, and no still-busy unit issued before f writes f's first or second source register. The two sources are tracked as separate cells.
- R3: A shadow hold on a unit has no effect on its `go_rd`.
- R4: `go_wr[f]` is high exactly when unit f is busy, has pulsed read-done, holds no shadow, and no still-busy unit issued before f reads f's destination without having pulsed read-done.
- R5: `iss_ready` is high exactly when the requested unit is idle, no busy unit targets the requested destination, and no live shadow row is receiving a bad resolution in that cycle. The issue takes effect at the clock edge when `iss_valid` and `iss_ready` are both high.
- R6: Arming an idle shadow row makes it live from the next cycle. A unit issued in the same cycle as the arm, or while the row is live, holds that row, and its `go_wr` stays low.
- R7: A good resolution of a live row frees the row and lifts its hold from every unit in the following cycle. A resolution pulse on a row that is not live is ignored.
- R8: A bad resolution of a live row makes every unit holding that row idle in the following cycle, without any write grant, and frees the row.
- R9: A write-done pulse makes the unit idle in the following cycle and releases, in that same cycle, every unit whose read waited on its result.
- R10: A read-done pulse drops the unit's `go_rd` in the following cycle and releases, in that same cycle, every later unit whose write waited on that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_fu | input | FU_W | Unit that receives the instruction |
| iss_dst | input | REG_W | Destination register |
| iss_src_a | input | REG_W | First source register |
| iss_src_b | input | REG_W | Second source register |
| iss_ready | output | 1 | Request can be accepted this cycle |
| rd_done | input | NUM_FU | Per-unit pulse: operands have been read |
| wr_done | input | NUM_FU | Per-unit pulse: result has been written |
| go_rd | output | NUM_FU | Per-unit permission to read operands |
| go_wr | output | NUM_FU | Per-unit permission to write the result |
| fu_busy | output | NUM_FU | Unit holds an instruction |
| sh_arm | input | NUM_SH | Per-row pulse: open a shadow |
| sh_good | input | NUM_SH | Per-row pulse: shadow resolved, keep work |
| sh_bad | input | NUM_SH | Per-row pulse: shadow resolved, cancel work |
| sh_live | output | NUM_SH | Shadow row is open |

## Verification
A directed run first builds specific hazard patterns. These include a chain where a reader waits on a writer through its first source. They also include a reader that blocks a later writer of its source, a duplicate destination, a shadowed unit that reads but cannot write, and one row resolved good while another is resolved bad. These patterns separate the read-after-write, write-after-read and write-after-write paths from each other and from the shadow hold. Constrained random traffic then runs over only eight registers. This forces frequent overlaps between sources and destinations, and a reference model based on issue order and register numbers checks every output on every cycle. The random traffic mixes completion pulses with arms and resolutions in the same cycle as issues, which exercises the same-cycle priority between clearing and setting cells.

// File: rtl/sb_pkg.sv
package sb_pkg;

  localparam int unsigned SB_VEC_MAX = 32;

  typedef logic [SB_VEC_MAX-1:0] sb_vec_t;

  // One-hot select wire for a unit or register index.
  function automatic sb_vec_t sb_decode(input int unsigned idx);
    sb_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // Next state of the shadow rows: a live row ends on any resolution,
  // an idle row opens on an arm.
  function automatic sb_vec_t sb_next_live(input sb_vec_t live, input sb_vec_t arm,
                                           input sb_vec_t ends);
    return (live & ~ends) | (~live & arm);
  endfunction

endpackage

// File: rtl/sb_reg_track.sv
module sb_reg_track
  import sb_pkg::*;
#(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_REG = 8,
  localparam int unsigned REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] iss_row,
  input  logic [REG_W-1:0]  dst,
  input  logic [REG_W-1:0]  src_a,
  input  logic [REG_W-1:0]  src_b,
  input  logic [NUM_FU-1:0] wr_clr,
  input  logic [NUM_FU-1:0] rd_clr,
  output logic [NUM_FU-1:0] pend_a,
  output logic [NUM_FU-1:0] pend_b,
  output logic [NUM_FU-1:0] pend_rd_dst,
  output logic              dst_taken
);

  // Per register: which units will write it, which units still must read it.
  logic [NUM_FU-1:0] writer_q [NUM_REG];
  logic [NUM_FU-1:0] reader_q [NUM_REG];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    logic hit_dst, hit_src;
    assign hit_dst = (dst == REG_W'(r));
    assign hit_src = (src_a == REG_W'(r)) || (src_b == REG_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        writer_q[r] <= '0;
        reader_q[r] <= '0;
      end else begin
        writer_q[r] <= (writer_q[r] & ~wr_clr) | (hit_dst ? iss_row : '0);
        reader_q[r] <= (reader_q[r] & ~rd_clr) | (hit_src ? iss_row : '0);
      end
    end

    // R5: destination stall keeps a single pending writer per register
    p_one_writer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(writer_q[r]));
  end

  // Cells about to be cleared this cycle must not be copied into a new row.
  assign pend_a      = writer_q[src_a] & ~wr_clr;
  assign pend_b      = writer_q[src_b] & ~wr_clr;
  assign pend_rd_dst = reader_q[dst] & ~rd_clr;
  assign dst_taken   = |writer_q[dst];

endmodule

// File: rtl/sb_dep_matrix.sv
module sb_dep_matrix #(
  parameter int unsigned NUM_FU = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FU-1:0] iss_row,
  input  logic [NUM_FU-1:0] new_a,
  input  logic [NUM_FU-1:0] new_b,
  input  logic [NUM_FU-1:0] new_war,
  input  logic [NUM_FU-1:0] raw_col_clr,
  input  logic [NUM_FU-1:0] war_col_clr,
  input  logic [NUM_FU-1:0] row_clr,
  output logic [NUM_FU-1:0] raw_blk,
  output logic [NUM_FU-1:0] war_blk
);

  for (genvar f = 0; f < NUM_FU; f++) begin : g_row
    logic [NUM_FU-1:0] a_q, b_q, w_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q <= '0;
        b_q <= '0;
        w_q <= '0;
      end else if (iss_row[f]) begin
        a_q <= new_a;
        b_q <= new_b;
        w_q <= new_war;
      end else if (row_clr[f]) begin
        a_q <= '0;
        b_q <= '0;
        w_q <= '0;
      end else begin
        a_q <= a_q & ~raw_col_clr;
        b_q <= b_q & ~raw_col_clr;
        w_q <= w_q & ~war_col_clr;
      end
    end

    assign raw_blk[f] = (|a_q) | (|b_q);
    assign war_blk[f] = |w_q;

    // R2: a unit never waits on itself
    p_no_self_dep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_q[f] || b_q[f] || w_q[f]));
  end

endmodule

// File: rtl/sb_shadow_rows.sv
module sb_shadow_rows
  import sb_pkg::*;
#(
  parameter int unsigned NUM_FU = 4,
  parameter int unsigned NUM_SH = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SH-1:0] arm,
  input  logic [NUM_SH-1:0] good,
  input  logic [NUM_SH-1:0] bad,
  input  logic [NUM_FU-1:0] iss_row,
  input  logic [NUM_FU-1:0] row_clr,
  output logic [NUM_SH-1:0] live,
  output logic [NUM_FU-1:0] hold_any,
  output logic [NUM_FU-1:0] cancel,
  output logic              any_bad
);

  logic [NUM_SH-1:0] live_q, good_eff, bad_eff, end_eff, new_hold;
  sb_vec_t           live_nx;

  assign good_eff = good & live_q;
  assign bad_eff  = bad & live_q;
  assign end_eff  = good_eff | bad_eff;
  assign new_hold = (live_q & ~good_eff) | (~live_q & arm);
  assign any_bad  = |bad_eff;
  assign live_nx  = sb_next_live(sb_vec_t'(live_q), sb_vec_t'(arm), sb_vec_t'(end_eff));
  assign live     = live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_nx[NUM_SH-1:0];
  end

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    logic [NUM_SH-1:0] hold_q;

    always_ff @(posedge clk) begin
      if (!rst_n)           hold_q <= '0;
      else if (iss_row[f])  hold_q <= new_hold;
      else if (row_clr[f])  hold_q <= '0;
      else                  hold_q <= hold_q & ~end_eff;
    end

    assign hold_any[f] = |hold_q;
    assign cancel[f]   = |(hold_q & bad_eff);

    // R6: a unit only ever holds rows that are live
    p_hold_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q & ~live_q) == '0);
  end

  for (genvar s = 0; s < NUM_SH; s++) begin : g_sh
    // R7: a good resolution frees its row on the next cycle
    p_good_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      good_eff[s] |=> !live_q[s]);
  end

endmodule

// File: rtl/sb_dep_scoreboard.sv
module sb_dep_scoreboard
  import sb_pkg::*;
#(
  parameter int unsigned NUM_FU  = 4,
  parameter int unsigned NUM_SH  = 2,
  parameter int unsigned NUM_REG = 8,
  localparam int unsigned FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
  localparam int unsigned REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [FU_W-1:0]   iss_fu,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [REG_W-1:0]  iss_src_a,
  input  logic [REG_W-1:0]  iss_src_b,
  output logic              iss_ready,
  input  logic [NUM_FU-1:0] rd_done,
  input  logic [NUM_FU-1:0] wr_done,
  output logic [NUM_FU-1:0] go_rd,
  output logic [NUM_FU-1:0] go_wr,
  output logic [NUM_FU-1:0] fu_busy,
  input  logic [NUM_SH-1:0] sh_arm,
  input  logic [NUM_SH-1:0] sh_good,
  input  logic [NUM_SH-1:0] sh_bad,
  output logic [NUM_SH-1:0] sh_live
);

  logic [NUM_FU-1:0] busy_q, rdone_q;
  logic [NUM_FU-1:0] wr_fire, rd_fire, cancel, free_fu, rd_clr;
  logic [NUM_FU-1:0] iss_row, pend_a, pend_b, pend_war;
  logic [NUM_FU-1:0] raw_blk, war_blk, hold_any;
  logic              dst_taken, any_bad, iss_fire;
  sb_vec_t           fu_sel;

  // Named internal events
  assign wr_fire  = wr_done & busy_q;
  assign rd_fire  = rd_done & busy_q & ~rdone_q;
  assign free_fu  = wr_fire | cancel;
  assign rd_clr   = rd_fire | free_fu;
  assign fu_sel   = sb_decode(32'(iss_fu));
  assign iss_ready = !busy_q[iss_fu] && !dst_taken && !any_bad;
  assign iss_fire = iss_valid && iss_ready;
  assign iss_row  = iss_fire ? fu_sel[NUM_FU-1:0] : '0;

  sb_reg_track #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_regs (
    .clk(clk), .rst_n(rst_n), .iss_row(iss_row),
    .dst(iss_dst), .src_a(iss_src_a), .src_b(iss_src_b),
    .wr_clr(free_fu), .rd_clr(rd_clr),
    .pend_a(pend_a), .pend_b(pend_b), .pend_rd_dst(pend_war),
    .dst_taken(dst_taken)
  );

  sb_dep_matrix #(.NUM_FU(NUM_FU)) u_matrix (
    .clk(clk), .rst_n(rst_n), .iss_row(iss_row),
    .new_a(pend_a), .new_b(pend_b), .new_war(pend_war),
    .raw_col_clr(free_fu), .war_col_clr(rd_clr), .row_clr(free_fu),
    .raw_blk(raw_blk), .war_blk(war_blk)
  );

  sb_shadow_rows #(.NUM_FU(NUM_FU), .NUM_SH(NUM_SH)) u_shadow (
    .clk(clk), .rst_n(rst_n), .arm(sh_arm), .good(sh_good), .bad(sh_bad),
    .iss_row(iss_row), .row_clr(free_fu), .live(sh_live),
    .hold_any(hold_any), .cancel(cancel), .any_bad(any_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      rdone_q <= '0;
    end else begin
      busy_q  <= (busy_q & ~free_fu) | iss_row;
      rdone_q <= (rdone_q | rd_fire) & ~free_fu & ~iss_row;
    end
  end

  assign go_rd   = busy_q & ~rdone_q & ~raw_blk;
  assign go_wr   = busy_q & rdone_q & ~war_blk & ~hold_any;
  assign fu_busy = busy_q;

  // R4: read and write permissions are never granted together
  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_rd & go_wr) == '0);

  // R5: an accepted issue occupies the named unit
  p_issue_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> busy_q[$past(iss_fu)]);

  for (genvar f = 0; f < NUM_FU; f++) begin : g_chk
    // R6: a held unit is never allowed to write
    p_hold_no_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_any[f] |-> !go_wr[f]);
    // R8: a cancelled unit is idle on the next cycle
    p_cancel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cancel[f] |=> !busy_q[f]);
    // R9: a written result frees the unit on the next cycle
    p_wr_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire[f] && !iss_row[f]) |=> !busy_q[f]);
  end

endmodule

// File: tb/tb_sb_dep_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_dep_scoreboard;

  localparam int NF = 4, NS = 2, NR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic iv; logic [1:0] fu; logic [2:0] d, sa, sb;
  logic [3:0] rdd, wrd; logic [1:0] arm, good, bad;
  logic iss_ready; logic [3:0] go_rd, go_wr, fu_busy; logic [1:0] sh_live;

  always #2 clk = ~clk;

  sb_dep_scoreboard #(.NUM_FU(NF), .NUM_SH(NS), .NUM_REG(NR)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iv), .iss_fu(fu), .iss_dst(d),
    .iss_src_a(sa), .iss_src_b(sb), .iss_ready(iss_ready),
    .rd_done(rdd), .wr_done(wrd), .go_rd(go_rd), .go_wr(go_wr),
    .fu_busy(fu_busy), .sh_arm(arm), .sh_good(good), .sh_bad(bad),
    .sh_live(sh_live));

  int n_chk = 0, n_fail = 0, seq_ctr = 0;
  bit done = 0;
  bit m_busy[NF], m_rdone[NF];
  int m_dst[NF], m_sa[NF], m_sb[NF], m_seq[NF];
  bit [1:0] m_hold[NF];
  bit [1:0] m_live;
  logic seen_ready;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  // Reference: order-based hazard rules restated over register numbers.
  function automatic bit m_go_rd(int f);
    if (!m_busy[f] || m_rdone[f]) return 0;
    for (int g = 0; g < NF; g++)
      if (g != f && m_busy[g] && m_seq[g] < m_seq[f] &&
          (m_dst[g] == m_sa[f] || m_dst[g] == m_sb[f])) return 0;
    return 1;
  endfunction

  function automatic bit m_go_wr(int f);
    if (!m_busy[f] || !m_rdone[f] || m_hold[f] != 0) return 0;
    for (int g = 0; g < NF; g++)
      if (g != f && m_busy[g] && !m_rdone[g] && m_seq[g] < m_seq[f] &&
          (m_sa[g] == m_dst[f] || m_sb[g] == m_dst[f])) return 0;
    return 1;
  endfunction

  function automatic bit m_ready(int u, int dd, bit [1:0] bd);
    if (m_busy[u]) return 0;
    for (int g = 0; g < NF; g++) if (m_busy[g] && m_dst[g] == dd) return 0;
    return (bd & m_live) == 0;
  endfunction

  function automatic int vec_rd(); int v = 0;
    for (int f = 0; f < NF; f++) v |= int'(m_go_rd(f)) << f; return v; endfunction
  function automatic int vec_wr(); int v = 0;
    for (int f = 0; f < NF; f++) v |= int'(m_go_wr(f)) << f; return v; endfunction
  function automatic int vec_busy(); int v = 0;
    for (int f = 0; f < NF; f++) v |= int'(m_busy[f]) << f; return v; endfunction

  task automatic m_update();
    bit [1:0] ge, be, nh; bit fire; bit can;
    ge = good & m_live; be = bad & m_live;
    fire = iv && m_ready(int'(fu), int'(d), bad);
    nh = (m_live & ~ge) | (~m_live & arm);
    for (int f = 0; f < NF; f++) begin
      can = m_busy[f] && ((m_hold[f] & be) != 0);
      if (can || (wrd[f] && m_busy[f])) begin
        m_busy[f] = 0; m_rdone[f] = 0; m_hold[f] = 0;
      end else begin
        if (rdd[f] && m_busy[f]) m_rdone[f] = 1;
        m_hold[f] = m_hold[f] & ~(ge | be);
      end
    end
    if (fire) begin
      m_busy[fu] = 1; m_rdone[fu] = 0; m_dst[fu] = d; m_sa[fu] = sa;
      m_sb[fu] = sb; m_seq[fu] = seq_ctr++; m_hold[fu] = nh;
    end
    m_live = (m_live & ~(ge | be)) | (~m_live & arm);
  endtask

  task automatic idle_in();
    iv = 0; fu = 0; d = 0; sa = 0; sb = 0; rdd = 0; wrd = 0; arm = 0; good = 0; bad = 0;
  endtask

  // Called just after a falling edge with inputs set; ends after the next one.
  task automatic step();
    #1;
    seen_ready = iss_ready;
    check("R5", "iss_ready", int'(iss_ready), int'(m_ready(int'(fu), int'(d), bad)));
    m_update();
    @(negedge clk);
    check("R2", "go_rd", int'(go_rd), vec_rd());
    check("R4", "go_wr", int'(go_wr), vec_wr());
    check("R9", "fu_busy", int'(fu_busy), vec_busy());
    check("R6", "sh_live", int'(sh_live), int'(m_live));
    idle_in();
  endtask

  task automatic issue(int u, int dd, int a, int b);
    iv = 1; fu = 2'(u); d = 3'(dd); sa = 3'(a); sb = 3'(b);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      m_busy[f] = 0; m_rdone[f] = 0; m_hold[f] = 0; m_seq[f] = 0;
      m_dst[f] = 0; m_sa[f] = 0; m_sb[f] = 0;
    end
    m_live = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    issue(2, 5, 1, 1); #1;
    check("R1", "reset busy", int'(fu_busy), 0);
    check("R1", "reset go_rd|go_wr", int'(go_rd | go_wr), 0);
    check("R1", "reset sh_live", int'(sh_live), 0);
    check("R1", "reset iss_ready", int'(iss_ready), 1);
    idle_in();
    @(negedge clk);

    // Read-after-write through the first source
    issue(0, 3, 1, 2); step();
    check("R2", "producer go_rd[0]", int'(go_rd[0]), 1);
    issue(1, 4, 3, 5); step();
    check("R2", "consumer go_rd[1] blocked", int'(go_rd[1]), 0);
    // Write-after-read: unit 2 writes r1 which unit 0 still reads
    issue(2, 1, 6, 6); step();
    // Write-after-write stall
    issue(3, 3, 0, 0); step();
    check("R5", "duplicate dst stalls", int'(seen_ready), 0);
    rdd = 4'b0101; step();
    check("R10", "go_rd[0] drops after read", int'(go_rd[0]), 0);
    check("R10", "go_wr[2] released by read", int'(go_wr[2]), 1);
    wrd = 4'b0001; step();
    check("R9", "unit 0 idle", int'(fu_busy[0]), 0);
    check("R9", "consumer released", int'(go_rd[1]), 1);

    // Shadow: unit 0 issued in the arm cycle
    arm = 2'b01; issue(0, 6, 7, 7); step();
    check("R3", "shadowed unit may read", int'(go_rd[0]), 1);
    rdd = 4'b0001; step();
    check("R6", "shadowed unit cannot write", int'(go_wr[0]), 0);
    good = 2'b10; step();
    check("R7", "resolve on idle row ignored", int'(sh_live), 1);
    good = 2'b01; step();
    check("R7", "hold lifted", int'(go_wr[0]), 1);
    wrd = 4'b0101; rdd = 4'b0010; step();
    wrd = 4'b0010; step();

    // Second row as a pending fault source, resolved bad
    arm = 2'b10; issue(0, 2, 0, 0); step();
    issue(3, 5, 2, 4); step();
    rdd = 4'b0001; bad = 2'b10; issue(1, 7, 0, 0); step();
    check("R8", "issue blocked on bad", int'(seen_ready), 0);
    check("R8", "shadowed units cancelled", int'(fu_busy), 0);
    check("R8", "row freed", int'(sh_live), 0);
    check("R8", "no write grant", int'(go_wr), 0);

    // Constrained random traffic
    for (int c = 0; c < 6000; c++) begin
      int r;
      for (int f = 0; f < NF; f++) begin
        if (m_go_rd(f) && ($urandom % 2 == 0)) rdd[f] = 1;
        if (m_go_wr(f) && ($urandom % 2 == 0)) wrd[f] = 1;
      end
      for (int s = 0; s < NS; s++) begin
        r = $urandom % 24;
        if (!m_live[s] && r < 2) arm[s] = 1;
        if (r == 5) good[s] = 1;
        if (r == 6) bad[s] = 1;
      end
      if ($urandom % 4 != 0)
        issue(int'($urandom % NF), int'($urandom % NR), int'($urandom % NR),
              int'($urandom % NR));
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial void'($urandom(32'd4711));

endmodule